// File: doc/BRIEF.md
# ADC Conversion Clock Generator

This block derives the conversion timing of an analog-to-digital converter from the peripheral bus clock. It does not produce a new clock net. It produces single-cycle enable pulses in the bus clock domain: `conv_tick` marks each conversion clock, and `sample_tick` marks the end of every sample.

The bus clock first passes through a fixed halving stage. In cascaded mode (`wide_mode` = 0), a 15-bit prescaler follows, then a 10-bit scaler. In wide mode (`wide_mode` = 1), one 16-bit divider follows the halving stage instead. Every conversion takes twelve conversion clocks.

Divider settings live in one 32-bit control word. Software writes it over a simple write port at a fixed address. A write, or a change of mode, restarts every counter from zero, so no count left over from an old setting leaks into the new period.

Top module: `adc_clkgen`

## Requirements
- R1: During reset both outputs stay low. Reset clears the control word to zero, so in cascaded mode the conversion period is 2 bus cycles.
- R2: The fixed halving stage means `conv_tick` is never high in two consecutive cycles. The shortest possible period is 2 cycles.
- R3: In cascaded mode the conversion period is 2 x (P+1) x (S+1) bus cycles. P is the control word bits [31:17] and S is bits [9:0].
- R4: In wide mode the conversion period is 2 x (D+1) bus cycles, where D is the control word bits [15:0].
- R5: Cascaded mode ignores control bits [16:10]. Wide mode ignores control bits [31:16].
- R6: `sample_tick` is high for one cycle, always together with `conv_tick`, on the 12th conversion tick after a restart and on every 12th tick after that.
- R7: A write with `bus_wr_en` = 1 and `bus_addr` = 0x0C loads the control word and zeroes all counters. The first conversion tick then falls in the last cycle of the first new period, that is, N-1 cycles after the cycle that follows the write edge, where N is the new period.
- R8: A write to any other address has no effect on the control word or on the tick phase.
- R9: A change of `wide_mode` restarts all counters in the same way as a write to the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data |
| wide_mode | input | 1 | 0 selects cascaded prescaler and scaler, 1 selects the single wide divider |
| conv_tick | output | 1 | One-cycle pulse per conversion clock |
| sample_tick | output | 1 | One-cycle pulse when a sample completes |

## Verification
Cascaded settings are tried with only the prescaler nonzero, with only the scaler nonzero, and with both nonzero. This shows that the two fields multiply rather than add, and that each field is taken from the correct bits. Wide-mode settings, and control words whose ignored bits are all set, separate the two field maps from each other. Restarts by write, by mode change, and by a write to a foreign address in the middle of a period tell a true reload apart from a counter that just keeps running. The sample strobe is timed from a restart and across two successive samples.

// File: rtl/adc_clkgen.sv
module adc_clkgen #(
  parameter int ADDR_W       = 8,
  parameter int REG_W        = 32,
  parameter int CLK_REG_ADDR = 'h0C,
  parameter int PRE_LSB      = 17,
  parameter int PRE_W        = 15,
  parameter int SCL_W        = 10,
  parameter int WIDE_W       = 16,
  parameter int CONV_PER_SMP = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              wide_mode,
  output logic              conv_tick,
  output logic              sample_tick
);
  localparam int SMP_W = $clog2(CONV_PER_SMP);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(CONV_PER_SMP - 1);

  logic [PRE_W-1:0]  pre_div, pre_cnt;
  logic [SCL_W-1:0]  scl_div, scl_cnt;
  logic [WIDE_W-1:0] wide_div, wide_cnt;
  logic [SMP_W-1:0]  smp_cnt;
  logic              half_q, mode_q;
  logic              wr_hit, restart, half_tick, pre_hit;
  logic              unused_wdata;

  assign wr_hit    = bus_wr_en && (bus_addr == ADDR_W'(CLK_REG_ADDR));
  assign restart   = wr_hit || (wide_mode != mode_q);
  assign half_tick = half_q;
  assign pre_hit   = half_tick && (pre_cnt == pre_div);
  assign conv_tick = mode_q ? (half_tick && (wide_cnt == wide_div))
                            : (pre_hit && (scl_cnt == scl_div));
  assign sample_tick  = conv_tick && (smp_cnt == SMP_LAST);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_div  <= '0;
      scl_div  <= '0;
      wide_div <= '0;
      mode_q   <= 1'b0;
    end else begin
      mode_q <= wide_mode;
      if (wr_hit) begin
        pre_div  <= bus_wdata[PRE_LSB +: PRE_W];
        scl_div  <= bus_wdata[0 +: SCL_W];
        wide_div <= bus_wdata[0 +: WIDE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      pre_cnt  <= '0;
      scl_cnt  <= '0;
      wide_cnt <= '0;
      smp_cnt  <= '0;
    end else if (restart) begin
      half_q   <= 1'b0;
      pre_cnt  <= '0;
      scl_cnt  <= '0;
      wide_cnt <= '0;
      smp_cnt  <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_tick) begin
        if (mode_q) begin
          wide_cnt <= (wide_cnt == wide_div) ? '0 : wide_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
          if (pre_hit)
            scl_cnt <= (scl_cnt == scl_div) ? '0 : scl_cnt + 1'b1;
        end
      end
      if (conv_tick)
        smp_cnt <= (smp_cnt == SMP_LAST) ? '0 : smp_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_clkgen_chk.sv
module adc_clkgen_chk #(
  parameter int ADDR_W       = 8,
  parameter int CLK_REG_ADDR = 'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              conv_tick,
  input logic              sample_tick
);
  AST_CONV_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick |=> !conv_tick); // R2
  AST_SAMPLE_WITH_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> conv_tick); // R6
  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick); // R6
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(CLK_REG_ADDR)) |=> (!conv_tick && !sample_tick)); // R7
endmodule

bind adc_clkgen adc_clkgen_chk #(.ADDR_W(ADDR_W), .CLK_REG_ADDR(CLK_REG_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .conv_tick(conv_tick), .sample_tick(sample_tick)
);

// File: tb/adc_clkgen_tb_top.sv
module adc_clkgen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        wide_mode = 1'b0;
  logic        conv_tick, sample_tick;
  int          n_run = 0, n_fail = 0, cyc = 0;
  bit          done = 1'b0;
  localparam int LIM = 5000;

  always #4 clk = ~clk;

  adc_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wide_mode(wide_mode),
    .conv_tick(conv_tick), .sample_tick(sample_tick)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); wide_mode = m;
    @(negedge clk);
  endtask

  task automatic step(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    while (!conv_tick && n < LIM) begin @(negedge clk); n++; end
  endtask

  // measures offset of first tick from current cycle and the next interval
  task automatic expect_ticks(int first, int period, string req);
    int n;
    wait_tick(n);
    check(n == first, {req, " first tick"}, n, first);
    @(negedge clk);
    wait_tick(n);
    check(n + 1 == period, {req, " period"}, n + 1, period);
  endtask

  task automatic t_reset;
    int n;
    step(3);
    check(!conv_tick && !sample_tick, "R1 outputs low in reset", {conv_tick, sample_tick}, 0);
    rst_n = 1'b1;
    step(2);
    wait_tick(n);
    @(negedge clk);
    wait_tick(n);
    check(n + 1 == 2, "R1 default period", n + 1, 2);
  endtask

  task automatic t_cascaded;
    do_write(8'h0C, (32'd2 << 17) | 32'd3);
    expect_ticks(23, 24, "R3 pre2 scl3");
    do_write(8'h0C, (32'd4 << 17));
    expect_ticks(9, 10, "R3 pre only");
    do_write(8'h0C, 32'd6);
    expect_ticks(13, 14, "R3 scl only");
  endtask

  task automatic t_wide;
    set_mode(1'b1);
    do_write(8'h0C, 32'd4);
    expect_ticks(9, 10, "R4 div4");
    do_write(8'h0C, 32'd0);
    expect_ticks(1, 2, "R2 min period wide");
    set_mode(1'b0);
  endtask

  task automatic t_ignored;
    do_write(8'h0C, (32'd1 << 17) | 32'h0001_FC00 | 32'd1);
    expect_ticks(7, 8, "R5 cascaded ignores [16:10]");
    set_mode(1'b1);
    do_write(8'h0C, 32'hFFFF_0002);
    expect_ticks(5, 6, "R5 wide ignores [31:16]");
    set_mode(1'b0);
  endtask

  task automatic t_sample;
    int n, ticks;
    do_write(8'h0C, (32'd1 << 17));
    n = 0; ticks = 0;
    while (!sample_tick && n < LIM) begin
      if (conv_tick) ticks++;
      @(negedge clk); n++;
    end
    check(n == 47, "R6 first sample offset", n, 47);
    check(conv_tick == 1'b1, "R6 sample with conv", conv_tick, 1);
    check(ticks + 1 == 12, "R6 conv ticks per sample", ticks + 1, 12);
    @(negedge clk);
    check(sample_tick == 1'b0, "R6 one cycle", sample_tick, 0);
    n = 1;
    while (!sample_tick && n < LIM) begin @(negedge clk); n++; end
    check(n == 48, "R6 sample spacing", n, 48);
  endtask

  task automatic t_reload;
    do_write(8'h0C, (32'd2 << 17) | 32'd3);
    step(10);
    do_write(8'h0C, (32'd2 << 17) | 32'd3);
    expect_ticks(23, 24, "R7 rewrite restarts");
  endtask

  task automatic t_decode;
    do_write(8'h0C, (32'd2 << 17) | 32'd3);
    step(4);
    do_write(8'h08, 32'd0);
    expect_ticks(17, 24, "R8 foreign address ignored");
  endtask

  task automatic t_mode;
    do_write(8'h0C, 32'h0006_0003);
    step(5);
    set_mode(1'b1);
    expect_ticks(7, 8, "R9 switch to wide");
    step(3);
    set_mode(1'b0);
    expect_ticks(31, 32, "R9 switch to cascaded");
  endtask

  initial begin
    t_reset;
    t_cascaded;
    t_wide;
    t_ignored;
    t_sample;
    t_reload;
    t_decode;
    t_mode;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 200000 && !done) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end
endmodule